// File: doc/BRIEF.md
# Register-Programmed SPI Master

This block is an SPI master driven entirely through a small 32-bit register file. Software picks a word length of 1 to 32 bits, the clock polarity and sampling phase, and which of four chip-select lines to use. It loads up to four right-justified words into a transmit FIFO, then writes a block count together with a start bit. The engine sends that many words MSB-first on `mosi`, captures `miso` into a four-word receive FIFO, and reports the end of the burst through a ready flag and an optional level interrupt.

The register port is a single-cycle strobe interface. `reg_wr` and `reg_rd` are never stalled, and read data is combinational from `reg_addr` in the same cycle. Data flows through the FIFOs, so back-pressure is reported and not enforced. A write to a full transmit FIFO is dropped and flags overflow. A read of an empty receive FIFO returns zero and flags underflow. A word received while the receive FIFO is full is discarded.

Register offsets: command 0x00, status 0x04, transfer control 0x08, clock divider 0x0C, transmit port 0x10 (write), receive port 0x14 (read).

Top module: `spim_ctrl`

## Requirements
- R1: After reset, the command register reads 0x1000_1000 (master bit 28 and software chip-select bit 12 set). Status reads 0x0280_0000 (receive empty bit 25, transmit empty bit 23). The divider reads 0, `sclk` is low, `irq` is low and every `cs_line` is high.
- R2: Command bits [4:0] hold the word length minus one. Each transmit word is taken from its low bits and sent MSB-first, with exactly that many bits per word.
- R3: Command bit 26 sets the idle `sclk` level (CPOL). Command bit 21 set means data is sampled on the trailing edge and changed on the leading edge (CPHA=1); clear means the reverse. `sclk` sits at the idle level whenever no burst runs.
- R4: With receive enable (command bit 14) set, each received word enters the receive FIFO right-justified, with the bits above the word length zero. With it clear, nothing is captured and the receive FIFO stays empty.
- R5: With transmit enable (command bit 15) clear, `mosi` stays 0 for the whole burst. Outside a burst `mosi` is always 0.
- R6: Writing transfer control with bit 31 set starts a burst of (bits [15:0] + 1) words. Status bit 31 (busy) is set during the burst. When it ends, busy clears, status bit 30 (ready) sets, and bit 31 of transfer control reads back 0.
- R7: Each `sclk` half period lasts (divider[7:0] + 1) system clock cycles.
- R8: Command bits [8:5] select chip-select lines 0..3. With bit 12 clear, the selected line is asserted only while busy. With bit 12 set, it is asserted when value bit 13 is 1. Asserted is low, or high when invert bit 16 is set. Unselected or deasserted lines sit at the opposite level.
- R9: Both FIFOs hold four words. Status bits 23/22 report transmit empty/full and 25/24 report receive empty/full. A transmit write when full is dropped and sets bit 26. A receive read when empty returns 0 and sets bit 27.
- R10: Writing 1 to status bit 30, 27 or 26 clears that flag. Writing 0 leaves it unchanged.
- R11: `irq` is high while ready is set and either (transfer-control bit 26 and transmit enable) or (bit 27 and receive enable) holds.
- R12: Writes to transfer control while busy are ignored: the running burst length and the stored count do not change, and no second burst starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the receive port) |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |
| irq | output | 1 | Level completion interrupt |
| sclk | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_line | output | 4 | Chip-select lines |

## Verification
The hardest situations to reach from the ports are the timing ones at word boundaries. These are the last sample of a word in trailing-edge mode, where the captured word must include the bit sampled on the very edge that ends it, and the reload of the next word without a gap. The bench runs a serial slave model that shifts `miso` bits out and records `mosi` on the edge the mode prescribes. It mixes random word lengths, modes, block counts and dividers with directed runs at lengths 1 and 32 in all four modes. A second start written while a slow burst is still running checks that the burst length is not disturbed mid-flight.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int WORD_W = 32;
  localparam int BLK_W  = 16;
  localparam int NCS    = 4;

  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [7:0] OFS_XCTL = 8'h08;
  localparam logic [7:0] OFS_DIV  = 8'h0C;
  localparam logic [7:0] OFS_TXD  = 8'h10;
  localparam logic [7:0] OFS_RXD  = 8'h14;

  // command bits
  localparam int C_CPOL   = 26;
  localparam int C_CPHA   = 21;
  localparam int C_INV    = 16;
  localparam int C_TXEN   = 15;
  localparam int C_RXEN   = 14;
  localparam int C_CSVAL  = 13;
  localparam int C_CSSW   = 12;
  localparam int C_SEL_LO = 5;
  localparam logic [31:0] CMD_RESET = 32'h1000_1000;

  // status bits
  localparam int S_BUSY = 31, S_RDY = 30, S_UNF = 27, S_OVF = 26;
  localparam int S_RXE = 25, S_RXF = 24, S_TXE = 23, S_TXF = 22;

  // transfer-control bits
  localparam int X_GO = 31, X_RXIE = 27, X_TXIE = 26;

  typedef enum logic [1:0] {SH_IDLE, SH_RUN, SH_HOLD} sh_state_e;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             full,
  output logic             empty,
  output logic [LVL_W-1:0] level
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             push_ok, pop_ok;

  assign full    = (level == LVL_W'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rp];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; level <= '0;
    end else begin
      if (push_ok) wp <= nxt(wp);
      if (pop_ok)  rp <= nxt(rp);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter
  import spim_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [4:0]       len_m1,
  input  logic             cpol,
  input  logic             cpha,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic [BLK_W-1:0] blk_m1,
  input  logic [DIV_W-1:0] half_m1,
  input  logic [31:0]      tx_word,
  input  logic             tx_avail,
  input  logic             miso,
  output logic             tx_pop,
  output logic             rx_push,
  output logic [31:0]      rx_word,
  output logic             busy,
  output logic             done,
  output logic             sclk,
  output logic             mosi
);
  sh_state_e        st;
  logic [DIV_W-1:0] hcnt;
  logic             sck_q, mosi_q;
  logic [31:0]      sh, rxsh, fetch, aligned, rx_full;
  logic [4:0]       bitcnt;
  logic [BLK_W-1:0] words_left;
  logic             tick, lead, trail, word_end, last_word, load;

  assign tick      = (st != SH_IDLE) && (hcnt == half_m1);
  assign lead      = (st == SH_RUN) && tick && !sck_q;
  assign trail     = (st == SH_RUN) && tick && sck_q;
  assign word_end  = trail && (bitcnt == len_m1);
  assign last_word = (words_left == '0);
  assign load      = ((st == SH_IDLE) && go) || (word_end && !last_word);
  assign fetch     = (tx_en && tx_avail) ? tx_word : '0;
  assign aligned   = fetch << (5'd31 - len_m1);
  assign tx_pop    = load && tx_en && tx_avail;
  // in trailing-edge mode the last bit arrives on the edge that ends the word
  assign rx_full   = cpha ? {rxsh[30:0], miso} : rxsh;
  assign rx_word   = rx_full & ~(32'hFFFF_FFFE << len_m1);
  assign rx_push   = word_end && rx_en;
  assign done      = (st == SH_HOLD) && tick;
  assign busy      = (st != SH_IDLE);
  assign sclk      = sck_q ^ cpol;
  assign mosi      = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= SH_IDLE; hcnt <= '0; sck_q <= 1'b0; mosi_q <= 1'b0;
      sh <= '0; rxsh <= '0; bitcnt <= '0; words_left <= '0;
    end else begin
      hcnt <= ((st == SH_IDLE) || tick) ? '0 : hcnt + 1'b1;
      case (st)
        SH_IDLE: if (go) begin
          st <= SH_RUN; words_left <= blk_m1; bitcnt <= '0; sck_q <= 1'b0;
        end
        SH_RUN: begin
          if (tick) sck_q <= ~sck_q;
          if ((lead && !cpha) || (trail && cpha)) rxsh <= {rxsh[30:0], miso};
          if (lead && cpha) begin
            mosi_q <= sh[31]; sh <= sh << 1;
          end
          if (trail) begin
            if (!cpha && !word_end) begin
              mosi_q <= sh[31]; sh <= sh << 1;
            end
            bitcnt <= bitcnt + 1'b1;
            if (word_end) begin
              bitcnt <= '0;
              if (last_word) st <= SH_HOLD;
              else words_left <= words_left - 1'b1;
            end
          end
        end
        SH_HOLD: if (tick) begin
          st <= SH_IDLE; mosi_q <= 1'b0;
        end
        default: st <= SH_IDLE;
      endcase
      if (load) begin
        if (!cpha) begin
          mosi_q <= aligned[31]; sh <= aligned << 1;
        end else begin
          sh <= aligned;
        end
      end
    end
  end
endmodule

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int DIV_W      = 8,
  parameter int ADDR_W     = 8,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic [NCS-1:0]    cs_line
);
  logic [31:0]       cmd_q;
  logic [BLK_W-1:0]  xc_cnt;
  logic              xc_txie, xc_rxie;
  logic [DIV_W-1:0]  div_q;
  logic              ready_q, ovf_q, unf_q;
  logic              busy, done, go;
  logic              tx_full, tx_empty, rx_full, rx_empty;
  logic              tx_pop, rx_push, tx_push, rx_pop;
  logic [31:0]       tx_dout, rx_dout, rx_word;
  logic [LVL_W-1:0]  tx_level, rx_level;
  logic              sel_cmd, sel_stat, sel_xctl, sel_div, sel_txd, sel_rxd;

  assign sel_cmd  = (reg_addr == ADDR_W'(OFS_CMD));
  assign sel_stat = (reg_addr == ADDR_W'(OFS_STAT));
  assign sel_xctl = (reg_addr == ADDR_W'(OFS_XCTL));
  assign sel_div  = (reg_addr == ADDR_W'(OFS_DIV));
  assign sel_txd  = (reg_addr == ADDR_W'(OFS_TXD));
  assign sel_rxd  = (reg_addr == ADDR_W'(OFS_RXD));

  assign go      = reg_wr && sel_xctl && !busy && reg_wdata[X_GO];
  assign tx_push = reg_wr && sel_txd;
  assign rx_pop  = reg_rd && sel_rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_RESET; xc_cnt <= '0; xc_txie <= 1'b0; xc_rxie <= 1'b0;
      div_q <= '0; ready_q <= 1'b0; ovf_q <= 1'b0; unf_q <= 1'b0;
    end else begin
      if (reg_wr && sel_cmd && !busy) cmd_q <= reg_wdata;
      if (reg_wr && sel_div && !busy) div_q <= reg_wdata[DIV_W-1:0];
      if (reg_wr && sel_xctl && !busy) begin
        xc_cnt  <= reg_wdata[BLK_W-1:0];
        xc_txie <= reg_wdata[X_TXIE];
        xc_rxie <= reg_wdata[X_RXIE];
      end
      if (reg_wr && sel_stat) begin
        if (reg_wdata[S_RDY]) ready_q <= 1'b0;
        if (reg_wdata[S_OVF]) ovf_q   <= 1'b0;
        if (reg_wdata[S_UNF]) unf_q   <= 1'b0;
      end
      if (go)                   ready_q <= 1'b0;
      if (done)                 ready_q <= 1'b1;
      if (tx_push && tx_full)   ovf_q   <= 1'b1;
      if (rx_pop && rx_empty)   unf_q   <= 1'b1;
    end
  end

  spim_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_txf (
    .clk, .rst_n, .push(tx_push), .din(reg_wdata), .pop(tx_pop),
    .dout(tx_dout), .full(tx_full), .empty(tx_empty), .level(tx_level));

  spim_fifo #(.DEPTH(FIFO_DEPTH), .W(32)) u_rxf (
    .clk, .rst_n, .push(rx_push), .din(rx_word), .pop(rx_pop),
    .dout(rx_dout), .full(rx_full), .empty(rx_empty), .level(rx_level));

  spim_shifter #(.DIV_W(DIV_W)) u_sh (
    .clk, .rst_n, .go, .len_m1(cmd_q[4:0]), .cpol(cmd_q[C_CPOL]),
    .cpha(cmd_q[C_CPHA]), .tx_en(cmd_q[C_TXEN]), .rx_en(cmd_q[C_RXEN]),
    .blk_m1(reg_wdata[BLK_W-1:0]), .half_m1(div_q), .tx_word(tx_dout),
    .tx_avail(!tx_empty), .miso, .tx_pop, .rx_push, .rx_word, .busy, .done,
    .sclk, .mosi);

  assign irq = ready_q && ((xc_txie && cmd_q[C_TXEN]) || (xc_rxie && cmd_q[C_RXEN]));

  // chip-select drive: one generated slice per line
  logic cs_assert;
  assign cs_assert = cmd_q[C_CSSW] ? cmd_q[C_CSVAL] : busy;
  for (genvar i = 0; i < NCS; i++) begin : g_cs
    assign cs_line[i] = (cmd_q[C_SEL_LO + i] && cs_assert) ? cmd_q[C_INV] : ~cmd_q[C_INV];
  end

  always_comb begin
    reg_rdata = '0;
    if (sel_cmd) reg_rdata = cmd_q;
    if (sel_div) reg_rdata[DIV_W-1:0] = div_q;
    if (sel_rxd && !rx_empty) reg_rdata = rx_dout;
    if (sel_xctl) begin
      reg_rdata[X_GO]         = busy;
      reg_rdata[X_RXIE]       = xc_rxie;
      reg_rdata[X_TXIE]       = xc_txie;
      reg_rdata[BLK_W-1:0]    = xc_cnt;
    end
    if (sel_stat) begin
      reg_rdata[S_BUSY] = busy;    reg_rdata[S_RDY] = ready_q;
      reg_rdata[S_UNF]  = unf_q;   reg_rdata[S_OVF] = ovf_q;
      reg_rdata[S_RXE]  = rx_empty; reg_rdata[S_RXF] = rx_full;
      reg_rdata[S_TXE]  = tx_empty; reg_rdata[S_TXF] = tx_full;
    end
  end
endmodule

// File: rtl/spim_ctrl_chk.sv
module spim_ctrl_chk #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 8,
  parameter int LVL_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              ready,
  input logic              irq,
  input logic              sclk,
  input logic              mosi,
  input logic              cpol,
  input logic              cs_sw,
  input logic              cs_inv,
  input logic [3:0]        cs_line,
  input logic [LVL_W-1:0]  tx_level,
  input logic              tx_full,
  input logic              ovf,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr
);
  logic tx_wr;
  assign tx_wr = reg_wr && (reg_addr == ADDR_W'(8'h10));

  AST_IDLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (sclk == cpol)); // R3
  AST_IDLE_DATA: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mosi); // R5
  AST_DONE_READY: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> ready); // R6
  AST_CS_HW_IDLE: assert property (@(posedge clk) disable iff (!rst_n) (!cs_sw && !busy) |-> (cs_line == {4{~cs_inv}})); // R8
  AST_TX_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) tx_level <= LVL_W'(DEPTH)); // R9
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovf) |-> $past(tx_wr && tx_full)); // R9
  AST_IRQ_READY: assert property (@(posedge clk) disable iff (!rst_n) irq |-> ready); // R11
endmodule

bind spim_ctrl spim_ctrl_chk #(.DEPTH(FIFO_DEPTH), .ADDR_W(ADDR_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .ready(ready_q), .irq(irq), .sclk(sclk),
  .mosi(mosi), .cpol(cmd_q[26]), .cs_sw(cmd_q[12]), .cs_inv(cmd_q[16]),
  .cs_line(cs_line), .tx_level(tx_level), .tx_full(tx_full), .ovf(ovf_q),
  .reg_wr(reg_wr), .reg_addr(reg_addr));

// File: tb/sim_spim_ctrl.sv
module sim_spim_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        irq, sclk, mosi, miso;
  logic [3:0]  cs_line;

  int checks = 0, failures = 0, cyc = 0;

  spim_ctrl u0 (.clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
                .reg_rdata, .irq, .sclk, .mosi, .miso, .cs_line);

  always #5 clk = ~clk;
  always @(posedge clk) cyc++;

  // ---------------- serial slave model ----------------
  logic        b_cpol = 0, b_cpha = 0, b_inv = 0;
  int          b_len = 8, b_sel = 0;
  logic [31:0] s_tx [8];
  logic [31:0] s_cap [8];
  logic [31:0] cap_sh = '0;
  logic [3:0]  cs_seen = '1;
  int          s_word = 0, s_bit = 0, edge_n = 0, t1 = 0, t2 = 0;

  assign miso = (s_bit < b_len) ? s_tx[s_word % 8][b_len - 1 - s_bit] : 1'b0;

  always @(sclk) begin
    if (cs_line[b_sel] == b_inv) begin
      edge_n++;
      if (edge_n == 1) t1 = cyc;
      if (edge_n == 2) t2 = cyc;
      if ((sclk != b_cpol) != b_cpha) begin
        if (s_word == 0 && s_bit == 0) cs_seen = cs_line;
        cap_sh = {cap_sh[30:0], mosi};
        s_bit++;
        if (s_bit == b_len) begin
          s_cap[s_word % 8] = cap_sh & mask(b_len);
          s_word++;
          s_bit = 0;
        end
      end
    end
  end

  // ---------------- helpers ----------------
  function automatic logic [31:0] mask(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 1);
  endfunction

  function automatic logic [31:0] cmd_word(input int len, input bit cpol, input bit cpha,
                                           input bit txe, input bit rxe, input int sel);
    return 32'(len - 1) | (32'd1 << (5 + sel)) | (32'(txe) << 15) | (32'(rxe) << 14) |
           (32'(cpha) << 21) | (32'(cpol) << 26) | (32'd1 << 28);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 0;
  endtask

  task automatic wait_ready();
    logic [31:0] s;
    for (int i = 0; i < 3000; i++) begin
      rd(8'h04, s);
      if (s[30]) return;
    end
  endtask

  logic [31:0] tx_exp [4];

  task automatic run_burst(input int len, input bit cpol, input bit cpha, input bit txe,
                           input bit rxe, input int n, input int dv, input int sel,
                           input bit txie, input bit rxie, input bit do_push);
    logic [31:0] v;
    wr(8'h0C, 32'(dv));
    wr(8'h00, cmd_word(len, cpol, cpha, txe, rxe, sel));
    b_len = len; b_cpol = cpol; b_cpha = cpha; b_inv = 0; b_sel = sel;
    s_word = 0; s_bit = 0; edge_n = 0; cs_seen = '1;
    for (int w = 0; w < 8; w++) begin s_tx[w] = $urandom; s_cap[w] = '0; end
    if (do_push && txe)
      for (int w = 0; w < n; w++) begin tx_exp[w] = $urandom; wr(8'h10, tx_exp[w]); end
    wr(8'h08, (32'd1 << 31) | (32'(rxie) << 27) | (32'(txie) << 26) | 32'(n - 1));
    wait_ready();
    rd(8'h04, v);
    check("R6 busy clear / ready set", {v[31], v[30]}, 32'b01);
    check("R6 word count", 32'(s_word), 32'(n));
    check("R7 half period", 32'(t2 - t1), 32'(dv + 1));
    check("R8 hw cs during burst", {28'd0, cs_seen}, {28'd0, ~(4'd1 << sel)});
    check("R8 hw cs after burst", {28'd0, cs_line}, 32'hF);
    check("R11 irq", {31'd0, irq}, {31'd0, (txie & txe) | (rxie & rxe)});
    for (int w = 0; w < n; w++)
      if (txe) check("R2 mosi word", s_cap[w], tx_exp[w] & mask(len));
      else     check("R5 mosi quiet", s_cap[w], 32'd0);
    if (rxe) begin
      for (int w = 0; w < n; w++) begin
        rd(8'h14, v);
        check("R4 rx word", v, s_tx[w] & mask(len));
      end
    end
    rd(8'h04, v);
    check("R4 rx fifo empty", {31'd0, v[25]}, 32'd1);
    check("R3 idle clock level", {31'd0, sclk}, {31'd0, cpol});
    rd(8'h08, v);
    check("R6 enable self-clear", {31'd0, v[31]}, 32'd0);
    wr(8'h04, 32'h4000_0000);
    rd(8'h04, v);
    check("R10 ready cleared", {31'd0, v[30]}, 32'd0);
    check("R11 irq low", {31'd0, irq}, 32'd0);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- main ----------------
  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 sclk", {31'd0, sclk}, 32'd0);
    check("R1 cs", {28'd0, cs_line}, 32'hF);
    check("R1 irq", {31'd0, irq}, 32'd0);
    rd(8'h00, v); check("R1 command", v, 32'h1000_1000);
    rd(8'h04, v); check("R1 status", v, 32'h0280_0000);
    rd(8'h0C, v); check("R1 divider", v, 32'd0);

    // R8 software chip select and inversion
    wr(8'h00, 32'h1000_1000 | (32'd1 << 13) | (32'd1 << 6));
    check("R8 sw cs asserted", {28'd0, cs_line}, 32'hD);
    wr(8'h00, 32'h1000_1000 | (32'd1 << 13) | (32'd1 << 6) | (32'd1 << 16));
    check("R8 sw cs inverted", {28'd0, cs_line}, 32'h2);
    wr(8'h00, 32'h1000_1000 | (32'd1 << 6));
    check("R8 sw cs value low", {28'd0, cs_line}, 32'hF);

    // R9 underflow, R10 write-zero keeps flag
    rd(8'h14, v); check("R9 empty read value", v, 32'd0);
    rd(8'h04, v); check("R9 underflow flag", {31'd0, v[27]}, 32'd1);
    wr(8'h04, 32'd0);
    rd(8'h04, v); check("R10 zero write keeps", {31'd0, v[27]}, 32'd1);
    wr(8'h04, 32'h0800_0000);
    rd(8'h04, v); check("R10 underflow cleared", {31'd0, v[27]}, 32'd0);

    // R9 overflow: five pushes into a four-word FIFO
    for (int w = 0; w < 4; w++) begin tx_exp[w] = $urandom; wr(8'h10, tx_exp[w]); end
    wr(8'h10, 32'hDEAD_BEEF);
    rd(8'h04, v);
    check("R9 tx full / not empty", {30'd0, v[22], v[23]}, 32'b10);
    check("R9 overflow flag", {31'd0, v[26]}, 32'd1);
    wr(8'h04, 32'h0400_0000);
    rd(8'h04, v); check("R10 overflow cleared", {31'd0, v[26]}, 32'd0);
    run_burst(32, 0, 0, 1, 0, 4, 0, 0, 1, 0, 0);  // dropped word must not appear (R9)

    // R2/R3/R4 corner lengths in all four modes
    for (int m = 0; m < 4; m++) begin
      run_burst(1,  m[1], m[0], 1, 1, 4, 0, m, 0, 1, 1);
      run_burst(32, m[1], m[0], 1, 1, 2, 1, m, 1, 0, 1);
    end
    // R5 transmit disabled, R4 receive disabled
    run_burst(8, 1, 1, 0, 1, 3, 0, 2, 1, 1, 1);
    run_burst(12, 0, 1, 1, 0, 3, 2, 1, 0, 1, 1);

    // R12 transfer-control writes ignored while busy
    wr(8'h0C, 32'd3);
    wr(8'h00, cmd_word(32, 0, 0, 1, 0, 0));
    b_len = 32; b_cpol = 0; b_cpha = 0; b_sel = 0; s_word = 0; s_bit = 0; edge_n = 0;
    wr(8'h10, 32'h1234_5678);
    wr(8'h08, 32'h8000_0000);
    wr(8'h08, 32'h8000_0003);
    rd(8'h04, v); check("R12 still busy", {31'd0, v[31]}, 32'd1);
    wait_ready();
    repeat (300) @(negedge clk);
    check("R12 one word only", 32'(s_word), 32'd1);
    rd(8'h08, v); check("R12 count unchanged", {16'd0, v[15:0]}, 32'd0);
    check("R2 busy-test word", s_cap[0], 32'h1234_5678);
    wr(8'h04, 32'h4000_0000);

    // constrained random bursts
    for (int k = 0; k < 18; k++) begin
      run_burst(($urandom % 32) + 1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                ($urandom % 4) + 1, $urandom % 4, $urandom % 4, 1'($urandom), 1'($urandom), 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule